// File: doc/BRIEF.md
# Guarded Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a small signal-processing core. It multiplies two signed 16-bit words and either loads the 32-bit product into a 36-bit accumulator or adds the product to it. One operation can issue every clock cycle, so an FIR filter runs at one tap per cycle. The two factors come from either the two data-memory read ports or the two register-file read ports, chosen per operation.

The four extra accumulator bits above the product give headroom for sixteen full-scale products. A round-and-saturate operation turns the accumulator into a 16-bit sample in one step. The accumulator can be written and read in three parts (low word, high word, headroom nibble) through the register-file path. This lets an interrupt handler save and restore it around a filter kernel. Instruction decode, the memories and the register file sit outside the block. The decoder presents a 4-bit operation code each cycle.

Top module: `mac_unit`

## Requirements
- R1: While the reset input is low, and for two clock edges after it rises, the accumulator is held at zero. Later reads of every part return 0x0000.
- R2: Operation code 1 (load product) replaces the accumulator with the signed 32-bit product of the two factors, sign-extended to 36 bits.
- R3: Operation code 2 (accumulate) adds the sign-extended product to the accumulator. Sixteen products of -32768 × -32768 accumulate to 2^34 without wrap-around.
- R4: For codes 1 and 2, `src_rf_i` = 0 takes the factors from `dm_a_i`/`dm_b_i`, and `src_rf_i` = 1 takes them from `rf_a_i`/`rf_b_i`.
- R5: Operation code 3 (round and saturate) adds 0x2000 to the accumulator in 37-bit arithmetic with no wrap. When the sum lies in [-0x20000000, 0x1FFFFFFF], `result_o` is sum bits [29:14] in the same cycle.
- R6: Under code 3, a rounded sum above 0x1FFFFFFF gives 0x7FFF and one below -0x20000000 gives 0x8000. This holds for the accumulator extremes too.
- R7: Codes 4, 5 and 6 write `rf_a_i` into accumulator bits [15:0], bits [31:16], and (from `rf_a_i[3:0]`) bits [35:32]. The other bits stay unchanged.
- R8: Codes 7, 8 and 9 drive `result_o` in the same cycle with accumulator bits [15:0], bits [31:16], and bits [35:32] sign-extended to 16 bits.
- R9: Codes 0 (idle), 3 and 7-9 leave the accumulator unchanged.
- R10: `result_o` is 0x0000 for codes 0, 1, 2, 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code for this cycle |
| src_rf_i | input | 1 | Factor source: 0 data memory, 1 register file |
| dm_a_i | input | 16 | First factor from data memory |
| dm_b_i | input | 16 | Second factor from data memory |
| rf_a_i | input | 16 | First register-file operand, also the write data for part writes |
| rf_b_i | input | 16 | Second register-file operand |
| result_o | output | 16 | Rounded sample or accumulator part |

## Verification
Codes that change the accumulator (1, 2, 4, 5, 6) take effect at the next rising edge. The bench therefore issues them at a falling edge and looks at their effect only through a read code issued at a later falling edge. Reads (7-9) and round-and-saturate (3) are combinational from the accumulator, so their result is due in the cycle they are presented. The bench samples `result_o` 2 ns after the falling edge that applied the code, well before the next rising edge. The expected values come from a 36-bit bench model that is updated only from the requirement definitions.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_MUL    = 4'd1,
    OP_MAC    = 4'd2,
    OP_RNDSAT = 4'd3,
    OP_WR_LO  = 4'd4,
    OP_WR_HI  = 4'd5,
    OP_WR_GD  = 4'd6,
    OP_RD_LO  = 4'd7,
    OP_RD_HI  = 4'd8,
    OP_RD_GD  = 4'd9
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16,
  localparam int PW = 2 * DW
) (
  input  logic signed [DW-1:0] fa_i,
  input  logic signed [DW-1:0] fb_i,
  output logic signed [PW-1:0] prod_o
);
  always_comb begin
    prod_o = fa_i * fb_i;
  end
endmodule

// File: rtl/mac_rndsat.sv
module mac_rndsat #(
  parameter int DW = 16,
  parameter int GW = 4,
  localparam int PW   = 2 * DW,
  localparam int AW   = PW + GW,
  localparam int FRAC = DW - 2,
  localparam int CHKW = AW - PW + 4
) (
  input  logic [AW-1:0] acc_i,
  output logic [DW-1:0] q_o
);
  logic [AW:0]      rnd;
  logic [CHKW-1:0]  top_bits;
  logic             in_range;

  always_comb begin
    rnd      = {acc_i[AW-1], acc_i} + ((AW+1)'(1) << (FRAC - 1));
    top_bits = rnd[AW:PW-3];
    in_range = (&top_bits) | ~(|top_bits);
    if (in_range) begin
      q_o = rnd[PW-3:FRAC];
    end else if (rnd[AW]) begin
      q_o = {1'b1, {(DW-1){1'b0}}};
    end else begin
      q_o = {1'b0, {(DW-1){1'b1}}};
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic          src_rf_i,
  input  logic [DW-1:0] dm_a_i,
  input  logic [DW-1:0] dm_b_i,
  input  logic [DW-1:0] rf_a_i,
  input  logic [DW-1:0] rf_b_i,
  output logic [DW-1:0] result_o
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;

  mac_op_e        op_e;
  logic [1:0]     rst_sync_q;
  logic           rst_n_int;
  logic [DW-1:0]  fa, fb;
  logic [PW-1:0]  prod;
  logic [AW-1:0]  prod_ext;
  logic [AW-1:0]  acc_q, acc_nxt;
  logic           acc_en;
  logic [DW-1:0]  sat_q;

  assign op_e = mac_op_e'(op_i);

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  // factor source select
  always_comb begin
    fa = src_rf_i ? rf_a_i : dm_a_i;
    fb = src_rf_i ? rf_b_i : dm_b_i;
  end

  mac_mult #(.DW(DW)) mult_i (
    .fa_i   (fa),
    .fb_i   (fb),
    .prod_o (prod)
  );

  assign prod_ext = {{GW{prod[PW-1]}}, prod};

  mac_rndsat #(.DW(DW), .GW(GW)) rndsat_i (
    .acc_i (acc_q),
    .q_o   (sat_q)
  );

  // accumulator next state
  always_comb begin
    acc_nxt = acc_q;
    acc_en  = 1'b0;
    case (op_e)
      OP_MUL: begin
        acc_nxt = prod_ext;
        acc_en  = 1'b1;
      end
      OP_MAC: begin
        acc_nxt = acc_q + prod_ext;
        acc_en  = 1'b1;
      end
      OP_WR_LO: begin
        acc_nxt = {acc_q[AW-1:DW], rf_a_i};
        acc_en  = 1'b1;
      end
      OP_WR_HI: begin
        acc_nxt = {acc_q[AW-1:PW], rf_a_i, acc_q[DW-1:0]};
        acc_en  = 1'b1;
      end
      OP_WR_GD: begin
        acc_nxt = {rf_a_i[GW-1:0], acc_q[PW-1:0]};
        acc_en  = 1'b1;
      end
      default: begin
        acc_nxt = acc_q;
        acc_en  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_nxt;
    end
  end

  // result select
  always_comb begin
    case (op_e)
      OP_RNDSAT: result_o = sat_q;
      OP_RD_LO:  result_o = acc_q[DW-1:0];
      OP_RD_HI:  result_o = acc_q[PW-1:DW];
      OP_RD_GD:  result_o = {{(DW-GW){acc_q[AW-1]}}, acc_q[AW-1:PW]};
      default:   result_o = '0;
    endcase
  end

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_e == OP_IDLE || op_e == OP_RNDSAT || op_e == OP_RD_LO ||
     op_e == OP_RD_HI || op_e == OP_RD_GD) |=> $stable(acc_q));

  // R3
  mac_step_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_e == OP_MAC) |=> ((acc_q - $past(acc_q)) == $past(prod_ext)));

  // R7
  guard_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_e == OP_WR_GD) |=> (acc_q[AW-1:PW] == $past(rf_a_i[GW-1:0]) &&
                             acc_q[PW-1:0] == $past(acc_q[PW-1:0])));

  // R7
  high_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_e == OP_WR_HI) |=> (acc_q[PW-1:DW] == $past(rf_a_i) &&
                             acc_q[DW-1:0] == $past(acc_q[DW-1:0]) &&
                             acc_q[AW-1:PW] == $past(acc_q[AW-1:PW])));

  // R5
  rnd_sign_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_e == OP_RNDSAT && !acc_q[AW-1]) |-> !result_o[DW-1]);
endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb_top;
  import mac_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_i;
  logic        src_rf_i;
  logic [15:0] dm_a_i, dm_b_i, rf_a_i, rf_b_i;
  logic [15:0] result_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic signed [35:0] m;

  mac_unit dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .src_rf_i (src_rf_i),
    .dm_a_i   (dm_a_i),
    .dm_b_i   (dm_b_i),
    .rf_a_i   (rf_a_i),
    .rf_b_i   (rf_b_i),
    .result_o (result_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rs_model(input logic signed [35:0] v);
    logic signed [36:0] r;
    r = {v[35], v} + 37'sd8192;
    if (r > 37'sd536870911)       return 16'h7FFF;
    else if (r < -37'sd536870912) return 16'h8000;
    else                          return r[29:14];
  endfunction

  // apply one operation at a falling edge and update the bench model
  task automatic exec(input mac_op_e op, input logic sel,
                      input logic [15:0] da, input logic [15:0] db,
                      input logic [15:0] ra, input logic [15:0] rb);
    logic signed [31:0] p;
    @(negedge clk);
    op_i = op; src_rf_i = sel;
    dm_a_i = da; dm_b_i = db; rf_a_i = ra; rf_b_i = rb;
    p = sel ? $signed(ra) * $signed(rb) : $signed(da) * $signed(db);
    case (op)
      OP_MUL:   m = 36'(p);
      OP_MAC:   m = m + 36'(p);
      OP_WR_LO: m[15:0]  = ra;
      OP_WR_HI: m[31:16] = ra;
      OP_WR_GD: m[35:32] = ra[3:0];
      default:  ;
    endcase
  endtask

  task automatic see(input mac_op_e op, input string req, input logic [15:0] exp);
    exec(op, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    #2;
    chk(req, result_o, exp);
  endtask

  task automatic read_all(input string req);
    see(OP_RD_LO, req, m[15:0]);
    see(OP_RD_HI, req, m[31:16]);
    see(OP_RD_GD, req, {{12{m[35]}}, m[35:32]});
  endtask

  task automatic load_acc(input logic [35:0] v);
    exec(OP_WR_GD, 1'b0, 16'h0, 16'h0, {12'h0, v[35:32]}, 16'h0);
    exec(OP_WR_HI, 1'b0, 16'h0, 16'h0, v[31:16], 16'h0);
    exec(OP_WR_LO, 1'b0, 16'h0, 16'h0, v[15:0], 16'h0);
  endtask

  task automatic t_reset();
    m = '0;
    read_all("R1");
  endtask

  task automatic t_mul_sources();
    exec(OP_MUL, 1'b0, 16'd300, -16'sd7, 16'd5, 16'd9);
    #2 chk("R10", result_o, 16'h0000);
    read_all("R2");
    exec(OP_MUL, 1'b1, 16'd300, -16'sd7, 16'h7FFF, 16'h8001);
    read_all("R4");
  endtask

  task automatic t_mac_chain();
    exec(OP_MUL, 1'b0, 16'h8000, 16'h8000, 16'h0, 16'h0);
    for (int i = 0; i < 15; i++) begin
      exec(OP_MAC, 1'b1, 16'h0, 16'h0, 16'h8000, 16'h8000);
      #2 chk("R10", result_o, 16'h0000);
    end
    read_all("R3");
    see(OP_RD_GD, "R3", 16'h0004);
    see(OP_RNDSAT, "R6", 16'h7FFF);
    exec(OP_MAC, 1'b0, 16'd1234, -16'sd4321, 16'h0, 16'h0);
    read_all("R3");
  endtask

  task automatic t_rndsat_range();
    logic [35:0] vals [8];
    vals[0] = 36'h000006000; vals[1] = 36'h000005FFF;
    vals[2] = 36'h01FFFDFFF; vals[3] = 36'h01FFFE000;
    vals[4] = 36'hFDFFFE000; vals[5] = 36'hFDFFFDFFF;
    vals[6] = 36'hFFFFFA000; vals[7] = 36'h000000000;
    for (int i = 0; i < 8; i++) begin
      load_acc(vals[i]);
      see(OP_RNDSAT, (i == 3 || i == 5) ? "R6" : "R5", rs_model(m));
    end
    see(OP_RD_LO, "R9", m[15:0]);
  endtask

  task automatic t_rndsat_extremes();
    load_acc(36'h7FFFFFFFF);
    see(OP_RNDSAT, "R6", 16'h7FFF);
    load_acc(36'h800000000);
    see(OP_RNDSAT, "R6", 16'h8000);
    read_all("R9");
  endtask

  task automatic t_partial_writes();
    load_acc(36'h3_1234_5678);
    read_all("R7");
    exec(OP_WR_HI, 1'b0, 16'h0, 16'h0, 16'hBEEF, 16'h0);
    #2 chk("R10", result_o, 16'h0000);
    read_all("R7");
    exec(OP_WR_GD, 1'b0, 16'h0, 16'h0, 16'hFFF9, 16'h0);
    see(OP_RD_GD, "R8", 16'hFFF9);
    read_all("R7");
  endtask

  task automatic t_hold();
    load_acc(36'hA_5A5A_C3C3);
    exec(OP_IDLE, 1'b0, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF);
    #2 chk("R10", result_o, 16'h0000);
    exec(OP_RNDSAT, 1'b1, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF);
    read_all("R9");
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_i = 4'd0; src_rf_i = 1'b0;
    dm_a_i = '0; dm_b_i = '0; rf_a_i = '0; rf_b_i = '0;
    m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mul_sources();
    t_mac_chain();
    t_rndsat_range();
    t_rndsat_extremes();
    t_partial_writes();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule